// File: doc/BRIEF.md
# Cascadable Nibble-Wide Segment Data Loader

This block collects display segment data four bits per shift clock and assembles an 80-position segment image inside four parallel shift lanes of 20 stages each. All state changes happen on the falling edge of the shift clock. A separate latch strobe copies the assembled image to the parallel segment outputs. The outputs therefore change only when the strobe is given, and never while a fill is in progress.

Several loaders can share one data bus and one shift clock. Each loader takes data only while it holds an enable token. That token enters on an active-low chain input. The loader arms on the first falling edge that sees this input low, and the data present on that arming edge is not stored. After exactly 20 stored nibbles the loader disarms itself and pulls its chain output low, which hands the token to the next loader.

A direction input does two things. It sets the shift direction of the lanes, and it decides which of the two bidirectional chain pins is the token input and which is the token output. A load strobe restarts the token logic so that a new fill can begin.

Top module: `seg_loader`

## Requirements
- R1: While reset is asserted, `seg_o` is all zero and the token output pin is high. The loader is then idle and not armed.
- R2: An idle loader arms on the first falling edge on which its token input pin is low and `load_i` is low. The nibble present on that arming edge is not stored.
- R3: With `dir_i` low, the k-th nibble stored after arming (k = 0..19) appears after a latch with bit b of `din_i` on `seg_o[4k+b]`. The first nibble therefore sits on `seg_o[3:0]` and the last on `seg_o[79:76]`.
- R4: With `dir_i` high, the k-th nibble stored appears with bit b on `seg_o[79-4k-b]`. The first nibble's bit 0 is on `seg_o[79]` and the last nibble's bit 3 is on `seg_o[0]`.
- R5: The token output pin stays high while 19 nibbles have been stored. The falling edge that stores the 20th nibble disarms the loader and drives the token output pin low. It stays low until `load_i` or reset.
- R6: Falling edges while the loader is idle or full do not alter the shift lanes, whatever `din_i` carries.
- R7: `load_i` high on a falling edge returns the loader to idle with a cleared nibble count, and no nibble is stored on that edge. Afterwards the token output pin is high. The shift lanes keep their contents.
- R8: `seg_o` takes the lane contents on a falling edge with `latch_i` high. On every other edge it holds its value.
- R9: With `dir_i` low, `chain_r_io` is the token input and `chain_l_io` carries the token output. With `dir_i` high the roles swap. A change of `dir_i` moves the token output to the other pin at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock, active on its falling edge |
| rst_n_i | input | 1 | Asynchronous active-low reset, released on the clock |
| dir_i | input | 1 | Shift direction and chain pin role select |
| load_i | input | 1 | Synchronous restart of the token logic |
| latch_i | input | 1 | Copies lane contents to the segment outputs |
| din_i | input | 4 | Segment data nibble |
| chain_r_io | inout | 1 | Right chain pin: token input when `dir_i` is low, output otherwise |
| chain_l_io | inout | 1 | Left chain pin: token output when `dir_i` is low, input otherwise |
| seg_o | output | 80 | Latched segment image, bit i is segment position i+1 |

## Verification
The properties assume that `dir_i` stays constant for the whole of a fill and that the token input pin does not change during the arming edge. They also assume that the input-side chain pin is always driven from outside, while the output-side pin is left to the loader. The stimulus changes `dir_i` and the chain drive only on rising clock edges, half a period away from the active edge. Before every fill it gives a load strobe with the token input high, so that each fill starts from idle. The bench routes its token drive to whichever pin `dir_i` currently names as the input.

// File: rtl/seg_loader_pkg.sv
`timescale 1ns/1ps
package seg_loader_pkg;

  // Token state of one loader in a chain
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FULL  = 2'd2
  } ld_state_e;

endpackage

// File: rtl/seg_rst_sync.sv
`timescale 1ns/1ps
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic sclk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(negedge sclk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/seg_enable_ctl.sv
`timescale 1ns/1ps
module seg_enable_ctl
  import seg_loader_pkg::*;
#(
  parameter int DEPTH = 20,
  localparam int CW   = $clog2(DEPTH)
) (
  input  logic          sclk_i,
  input  logic          rst_n_i,
  input  logic          load_i,
  input  logic          tok_in_n_i,
  output logic          shift_en_o,
  output logic          tok_out_n_o,
  output ld_state_e     state_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  ld_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (load_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (!tok_in_n_i) st_d = ST_ARMED;
        ST_ARMED: begin
          if (cnt_q == LAST) begin
            st_d  = ST_FULL;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FULL:  st_d = ST_FULL;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(negedge sclk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign shift_en_o  = (st_q == ST_ARMED) && !load_i;
  assign tok_out_n_o = (st_q != ST_FULL);
  assign state_o     = st_q;
  assign cnt_o       = cnt_q;

endmodule

// File: rtl/seg_shift_lanes.sv
`timescale 1ns/1ps
module seg_shift_lanes #(
  parameter int LANES = 4,
  parameter int DEPTH = 20
) (
  input  logic                   sclk_i,
  input  logic                   rst_n_i,
  input  logic                   shift_en_i,
  input  logic                   dir_i,
  input  logic [LANES-1:0]       din_i,
  output logic [LANES*DEPTH-1:0] flat_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DEPTH-1:0] lane_q, lane_d;

    // dir low: enter at top stage, move down; dir high: mirrored lane, move up
    always_comb begin
      if (!dir_i) lane_d = {din_i[k], lane_q[DEPTH-1:1]};
      else        lane_d = {lane_q[DEPTH-2:0], din_i[LANES-1-k]};
    end

    always_ff @(negedge sclk_i or negedge rst_n_i) begin
      if (!rst_n_i)        lane_q <= '0;
      else if (shift_en_i) lane_q <= lane_d;
    end

    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      assign flat_o[j*LANES + k] = lane_q[j];
    end
  end

endmodule

// File: rtl/seg_loader.sv
`timescale 1ns/1ps
module seg_loader
  import seg_loader_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 20
) (
  input  logic                   sclk_i,
  input  logic                   rst_n_i,
  input  logic                   dir_i,
  input  logic                   load_i,
  input  logic                   latch_i,
  input  logic [LANES-1:0]       din_i,
  inout  wire                    chain_r_io,
  inout  wire                    chain_l_io,
  output logic [LANES*DEPTH-1:0] seg_o
);

  localparam int NSEG = LANES * DEPTH;
  localparam int CW   = $clog2(DEPTH);

  logic            rst_sync_n;
  logic            shift_en;
  logic            tok_in_n;
  logic            tok_out_n;
  ld_state_e       ctl_st;
  logic [CW-1:0]   ctl_cnt;
  logic [NSEG-1:0] lanes_flat;
  logic [NSEG-1:0] seg_q;

  // chain pin roles follow the shift direction
  assign tok_in_n   = dir_i ? chain_l_io : chain_r_io;
  assign chain_l_io = dir_i ? 1'bz : tok_out_n;
  assign chain_r_io = dir_i ? tok_out_n : 1'bz;

  seg_rst_sync #(.STAGES(2)) rst_sync_i (
    .sclk_i   (sclk_i),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_sync_n)
  );

  seg_enable_ctl #(.DEPTH(DEPTH)) ctl_i (
    .sclk_i      (sclk_i),
    .rst_n_i     (rst_sync_n),
    .load_i      (load_i),
    .tok_in_n_i  (tok_in_n),
    .shift_en_o  (shift_en),
    .tok_out_n_o (tok_out_n),
    .state_o     (ctl_st),
    .cnt_o       (ctl_cnt)
  );

  seg_shift_lanes #(.LANES(LANES), .DEPTH(DEPTH)) lanes_i (
    .sclk_i     (sclk_i),
    .rst_n_i    (rst_sync_n),
    .shift_en_i (shift_en),
    .dir_i      (dir_i),
    .din_i      (din_i),
    .flat_o     (lanes_flat)
  );

  // output image register
  always_ff @(negedge sclk_i or negedge rst_sync_n) begin
    if (!rst_sync_n)  seg_q <= '0;
    else if (latch_i) seg_q <= lanes_flat;
  end

  assign seg_o = seg_q;

endmodule

// File: rtl/seg_loader_chk.sv
`timescale 1ns/1ps
module seg_loader_chk
  import seg_loader_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 20,
  localparam int CW   = $clog2(DEPTH),
  localparam int NSEG = LANES * DEPTH
) (
  input logic            sclk_i,
  input logic            rst_n_i,
  input logic            load_i,
  input logic            latch_i,
  input logic            tok_in_n_i,
  input logic            shift_en_i,
  input ld_state_e       st_i,
  input logic [CW-1:0]   cnt_i,
  input logic [NSEG-1:0] lanes_i,
  input logic [NSEG-1:0] seg_i
);

  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  p_arm_r2: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    (st_i == ST_IDLE && !load_i && !tok_in_n_i) |=> (st_i == ST_ARMED));

  p_cnt_bound_r5: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    cnt_i <= LAST);

  p_handoff_r5: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    (st_i == ST_ARMED && cnt_i == LAST && !load_i) |=> (st_i == ST_FULL));

  p_full_holds_r5: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    (st_i == ST_FULL && !load_i) |=> (st_i == ST_FULL));

  p_lanes_frozen_r6: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    !shift_en_i |=> $stable(lanes_i));

  p_stay_idle_r6: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    (st_i == ST_IDLE && tok_in_n_i) |=> (st_i == ST_IDLE));

  p_load_clears_r7: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    load_i |=> (st_i == ST_IDLE && cnt_i == '0 && $stable(lanes_i)));

  p_latch_copy_r8: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    latch_i |=> (seg_i == $past(lanes_i)));

  p_seg_hold_r8: assert property (@(negedge sclk_i) disable iff (!rst_n_i)
    !latch_i |=> $stable(seg_i));

endmodule

bind seg_loader seg_loader_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .sclk_i     (sclk_i),
  .rst_n_i    (rst_sync_n),
  .load_i     (load_i),
  .latch_i    (latch_i),
  .tok_in_n_i (tok_in_n),
  .shift_en_i (shift_en),
  .st_i       (ctl_st),
  .cnt_i      (ctl_cnt),
  .lanes_i    (lanes_flat),
  .seg_i      (seg_o)
);

// File: tb/seg_loader_tb_top.sv
`timescale 1ns/1ps
module seg_loader_tb_top;

  localparam int NV = 4;
  // per-row: direction, first nibble, nibble step, expected seg_o[3:0], expected seg_o[79:76]
  localparam logic [NV-1:0] T_DIR    = 4'b1010;
  localparam logic [3:0]    T_SEED [NV] = '{4'h1, 4'h0, 4'hA, 4'h2};
  localparam logic [3:0]    T_STEP [NV] = '{4'h1, 4'h3, 4'h5, 4'h7};
  localparam logic [3:0]    T_LO   [NV] = '{4'h1, 4'h9, 4'hA, 4'hE};
  localparam logic [3:0]    T_HI   [NV] = '{4'h4, 4'h0, 4'h9, 4'h4};

  logic        clk = 1'b0;
  logic        rst_n, dir, load, latch, tok_drv;
  logic [3:0]  din;
  logic [79:0] seg;
  logic [79:0] exp_last, exp_part;
  wire         chain_r, chain_l;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  assign chain_r = dir ? 1'bz : tok_drv;
  assign chain_l = dir ? tok_drv : 1'bz;

  seg_loader dut_i (
    .sclk_i     (clk),
    .rst_n_i    (rst_n),
    .dir_i      (dir),
    .load_i     (load),
    .latch_i    (latch),
    .din_i      (din),
    .chain_r_io (chain_r),
    .chain_l_io (chain_l),
    .seg_o      (seg)
  );

  function automatic logic [3:0] nib(input logic [3:0] seed, input logic [3:0] stp, input int i);
    return 4'(int'(seed) + i * int'(stp));
  endfunction

  function automatic logic [79:0] exp_img(input logic d, input logic [3:0] seed, input logic [3:0] stp);
    logic [79:0] v = '0;
    for (int i = 0; i < 20; i++)
      for (int b = 0; b < 4; b++)
        if (d) v[79 - 4*i - b] = nib(seed, stp, i)[b];
        else   v[4*i + b]      = nib(seed, stp, i)[b];
    return v;
  endfunction

  function automatic logic tok_out();
    return dir ? chain_r : chain_l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
  endtask

  // one complete fill in direction d, ending with a latch
  task automatic fill(input logic d, input logic [3:0] seed, input logic [3:0] stp);
    step(); dir = d; tok_drv = 1'b1; load = 1'b1;
    step(); load = 1'b0; tok_drv = 1'b0; din = 4'hF;   // arming edge: nibble must be dropped
    for (int i = 0; i < 20; i++) begin
      step();
      if (i == 19) check(tok_out() == 1'b1, "R5 token high after 19 nibbles", 80'(tok_out()), 80'd1);
      din = nib(seed, stp, i);
    end
    step();
    check(tok_out() == 1'b0, "R5 token low after 20 nibbles", 80'(tok_out()), 80'd0);
    latch = 1'b1; din = 4'h0;
    step(); latch = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; dir = 1'b0; load = 1'b0; latch = 1'b0; tok_drv = 1'b1; din = 4'h0;
    repeat (3) step();
    // R1 reset state
    check(seg == '0, "R1 seg zero in reset", seg, '0);
    check(chain_l == 1'b1, "R1 token output high in reset", 80'(chain_l), 80'd1);
    rst_n = 1'b1;
    repeat (4) step();

    // table-driven fills (R2, R3, R4, R9 pin roles per direction)
    for (int r = 0; r < NV; r++) begin
      fill(T_DIR[r], T_SEED[r], T_STEP[r]);
      exp_last = exp_img(T_DIR[r], T_SEED[r], T_STEP[r]);
      check(seg == exp_last, T_DIR[r] ? "R4 R2 full image dir high" : "R3 R2 full image dir low", seg, exp_last);
      check(seg[3:0] == T_LO[r], "R3 R4 lowest group", 80'(seg[3:0]), 80'(T_LO[r]));
      check(seg[79:76] == T_HI[r], "R3 R4 highest group", 80'(seg[79:76]), 80'(T_HI[r]));
    end

    // R6: loader full, token input still low, extra edges ignored
    for (int i = 0; i < 5; i++) begin step(); din = 4'(i + 3); end
    step(); latch = 1'b1;
    step(); latch = 1'b0;
    step();
    check(seg == exp_last, "R6 edges ignored when full", seg, exp_last);
    check(chain_r == 1'b0, "R5 token stays low while full", 80'(chain_r), 80'd0);

    // R9: direction change moves token output to the other pin
    dir = 1'b0;
    #1;
    check(chain_l == 1'b0, "R9 token output moves to left pin", 80'(chain_l), 80'd0);

    // R7: load returns token output high
    step(); tok_drv = 1'b1; load = 1'b1;
    step(); load = 1'b0;
    step();
    check(chain_l == 1'b1, "R7 token high after load", 80'(chain_l), 80'd1);

    // R6: idle with token input high, edges ignored
    for (int i = 0; i < 20; i++) begin step(); din = 4'(i); end
    step(); latch = 1'b1;
    step(); latch = 1'b0;
    step();
    check(seg == exp_last, "R6 edges ignored when idle", seg, exp_last);
    check(chain_l == 1'b1, "R2 no arming with token input high", 80'(chain_l), 80'd1);

    // R7/R8: partial fill of 5 nibbles cut by load, outputs hold until latch
    step(); tok_drv = 1'b0; din = 4'hF;
    for (int i = 0; i < 5; i++) begin step(); din = nib(4'h6, 4'h3, i); end
    step(); load = 1'b1; tok_drv = 1'b1; din = 4'hC;
    step(); load = 1'b0;
    check(seg == exp_last, "R8 outputs hold without latch", seg, exp_last);
    check(chain_l == 1'b1, "R7 token high after mid-fill load", 80'(chain_l), 80'd1);
    latch = 1'b1;
    step(); latch = 1'b0;
    for (int j = 0; j < 20; j++)
      for (int b = 0; b < 4; b++)
        exp_part[4*j + b] = (j < 15) ? exp_last[4*(j+5) + b] : nib(4'h6, 4'h3, j - 15)[b];
    check(seg == exp_part, "R7 R8 partial image after latch", seg, exp_part);

    // R1: reset again from a loaded state
    step(); rst_n = 1'b0;
    #1;
    check(seg == '0, "R1 seg cleared by reset", seg, '0);
    check(chain_l == 1'b1, "R1 token high in reset", 80'(chain_l), 80'd1);
    step(); rst_n = 1'b1;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule